// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block resolves the longest matching route for a 32-bit IPv4 destination in two fixed-stride table reads. The upper bits of the address index a first table. Each entry in that table holds one of two things. It can hold a finished next hop, which is the common case because almost all routes are 24 bits or shorter. Otherwise it holds the number of a second-level block. In that case the next eight address bits select one entry inside that block, and that entry supplies the next hop.

The block takes one lookup per clock. Every lookup returns after exactly two cycles, and results leave in the order the lookups arrived. A lookup resolved at the first level still passes through the second stage and keeps its slot, so ordering holds without any reorder logic. Software loads both tables through a single write port, with routes already expanded to the table strides. Any entry that has not been written since reset returns a configurable default-route next hop.

The first-level index width `L1_W` is a parameter. With the full 24-bit stride the first table has 2^24 entries. The default of 10 bits keeps the model small and still exercises the same two-read scheme.

Top module: `prefix_lookup_engine`

## Requirements
- R1: A lookup whose first-level entry (index = address bits [31:32-L1_W]) was written with flag bit NH_W equal to 0 returns that entry's low NH_W bits as next hop, with res_lvl2_o = 0.
- R2: A lookup whose first-level entry was written with flag bit NH_W equal to 1 returns the second-level entry at write address {entry[BLK_W-1:0], address bits [31-L1_W -: 8]}, with res_lvl2_o = 1.
- R3: res_valid_o rises exactly two clock edges after the edge that samples lk_valid_i high. Back-to-back lookups produce back-to-back results in issue order.
- R4: An unwritten first-level entry yields DEFAULT_NH with res_lvl2_o = 0. An unwritten entry in a pointed-to second-level block yields DEFAULT_NH with res_lvl2_o = 1.
- R5: A first-level write (wr_tbl_i = 0) is seen only by lookups accepted in later cycles. A second-level write (wr_tbl_i = 1) is seen by lookups accepted in the same cycle or later, but not by a lookup accepted one cycle earlier.
- R6: Reset clears res_valid_o and marks every table entry unwritten.
- R7: While res_valid_o is 0, res_nh_o and res_lvl2_o are 0.
- R8: With prefix-expanded routes loaded, every result equals the next hop of the longest loaded prefix that covers the address, or DEFAULT_NH if no prefix covers it.
- R9: Writing an entry again replaces its previous contents for later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_addr_i | input | ADDR_W | Destination address |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 1 | 0 = first-level table, 1 = second-level table |
| wr_addr_i | input | WA_W | Entry index; for the second level {block, offset} |
| wr_data_i | input | NH_W+1 | Entry: bit NH_W = pointer flag, low bits = next hop or block |
| res_valid_o | output | 1 | Result valid |
| res_nh_o | output | NH_W | Resolved next hop |
| res_lvl2_o | output | 1 | Result came from the second level |

## Verification
A table write and a lookup can land in the same cycle. The two levels are read at different pipeline edges, so they see that write differently. The bench issues a lookup together with a first-level write to the same index, which must return the old entry. It then issues a second-level write one cycle after a lookup and also in the same cycle as a lookup. The first of these must return the old value and the second the new one. Each outcome is compared against the values known to be in the table before and after the write.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic {
    TBL_L1 = 1'b0,
    TBL_L2 = 1'b1
  } tbl_sel_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lpm_l1_stage.sv
module lpm_l1_stage #(
  parameter int L1_W = 10,
  parameter int L2_W = 8,
  parameter int NH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lk_valid_i,
  input  logic [L1_W-1:0] lk_idx_i,
  input  logic [L2_W-1:0] lk_off_i,
  input  logic            wr_en_i,
  input  logic [L1_W-1:0] wr_idx_i,
  input  logic [NH_W:0]   wr_entry_i,
  output logic            s1_valid_o,
  output logic            s1_hit_o,
  output logic [NH_W:0]   s1_entry_o,
  output logic [L2_W-1:0] s1_off_o
);
  localparam int L1_DEPTH = 1 << L1_W;

  logic [NH_W:0]       tbl_q [L1_DEPTH];
  logic [L1_DEPTH-1:0] written_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tbl_q[wr_idx_i] <= wr_entry_i;
  end

  // read uses pre-write contents at the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q  <= '0;
      s1_valid_o <= 1'b0;
      s1_hit_o   <= 1'b0;
      s1_entry_o <= '0;
      s1_off_o   <= '0;
    end else begin
      if (wr_en_i) written_q[wr_idx_i] <= 1'b1;
      s1_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        s1_hit_o   <= written_q[lk_idx_i];
        s1_entry_o <= tbl_q[lk_idx_i];
        s1_off_o   <= lk_off_i;
      end
    end
  end
endmodule

// File: rtl/lpm_l2_stage.sv
module lpm_l2_stage #(
  parameter int                L2_W       = 8,
  parameter int                NUM_BLK    = 8,
  parameter int                NH_W       = 8,
  parameter logic [NH_W-1:0]   DEFAULT_NH = '1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          s1_valid_i,
  input  logic                          s1_hit_i,
  input  logic [NH_W:0]                 s1_entry_i,
  input  logic [L2_W-1:0]               s1_off_i,
  input  logic                          wr_en_i,
  input  logic [$clog2(NUM_BLK)+L2_W-1:0] wr_idx_i,
  input  logic [NH_W-1:0]               wr_nh_i,
  output logic                          res_valid_o,
  output logic [NH_W-1:0]               res_nh_o,
  output logic                          res_lvl2_o
);
  localparam int BLK_W    = $clog2(NUM_BLK);
  localparam int L2_IDX_W = BLK_W + L2_W;
  localparam int L2_DEPTH = NUM_BLK << L2_W;

  logic [NH_W-1:0]     tbl_q [L2_DEPTH];
  logic [L2_DEPTH-1:0] written_q;
  logic                is_ptr;
  logic [L2_IDX_W-1:0] rd_idx;
  logic [NH_W-1:0]     l1_nh;

  assign is_ptr = s1_hit_i & s1_entry_i[NH_W];
  assign rd_idx = {s1_entry_i[BLK_W-1:0], s1_off_i};
  assign l1_nh  = s1_hit_i ? s1_entry_i[NH_W-1:0] : DEFAULT_NH;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tbl_q[wr_idx_i] <= wr_nh_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q   <= '0;
      res_valid_o <= 1'b0;
      res_nh_o    <= '0;
      res_lvl2_o  <= 1'b0;
    end else begin
      if (wr_en_i) written_q[wr_idx_i] <= 1'b1;
      res_valid_o <= s1_valid_i;
      if (!s1_valid_i) begin
        res_nh_o   <= '0;
        res_lvl2_o <= 1'b0;
      end else if (is_ptr) begin
        res_nh_o   <= written_q[rd_idx] ? tbl_q[rd_idx] : DEFAULT_NH;
        res_lvl2_o <= 1'b1;
      end else begin
        res_nh_o   <= l1_nh;  // first-level result rides its slot
        res_lvl2_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prefix_lookup_engine.sv
module prefix_lookup_engine #(
  parameter int              ADDR_W     = 32,
  parameter int              L1_W       = 10,
  parameter int              L2_W       = 8,
  parameter int              NUM_BLK    = 8,
  parameter int              NH_W       = 8,
  parameter logic [NH_W-1:0] DEFAULT_NH = 8'hFE,
  parameter int              WA_W       = lpm_pkg::max_int(L1_W, $clog2(NUM_BLK) + L2_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              wr_en_i,
  input  logic              wr_tbl_i,
  input  logic [WA_W-1:0]   wr_addr_i,
  input  logic [NH_W:0]     wr_data_i,
  output logic              res_valid_o,
  output logic [NH_W-1:0]   res_nh_o,
  output logic              res_lvl2_o
);
  localparam int BLK_W    = $clog2(NUM_BLK);
  localparam int L2_IDX_W = BLK_W + L2_W;
  localparam int LOW_W    = ADDR_W - L1_W - L2_W;

  logic            wr_l1, wr_l2;
  logic            s1_valid, s1_hit;
  logic [NH_W:0]   s1_entry;
  logic [L2_W-1:0] s1_off;

  assign wr_l1 = wr_en_i && (wr_tbl_i == lpm_pkg::TBL_L1);
  assign wr_l2 = wr_en_i && (wr_tbl_i == lpm_pkg::TBL_L2);

  generate
    if (LOW_W > 0) begin : g_low_bits
      logic unused_low;
      assign unused_low = ^lk_addr_i[LOW_W-1:0];
    end
    if (WA_W > L2_IDX_W) begin : g_wa_l2
      logic unused_wa_l2;
      assign unused_wa_l2 = ^wr_addr_i[WA_W-1:L2_IDX_W];
    end
    if (WA_W > L1_W) begin : g_wa_l1
      logic unused_wa_l1;
      assign unused_wa_l1 = ^wr_addr_i[WA_W-1:L1_W];
    end
  endgenerate

  lpm_l1_stage #(
    .L1_W(L1_W), .L2_W(L2_W), .NH_W(NH_W)
  ) u_l1 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_valid_i (lk_valid_i),
    .lk_idx_i   (lk_addr_i[ADDR_W-1 -: L1_W]),
    .lk_off_i   (lk_addr_i[ADDR_W-1-L1_W -: L2_W]),
    .wr_en_i    (wr_l1),
    .wr_idx_i   (wr_addr_i[L1_W-1:0]),
    .wr_entry_i (wr_data_i),
    .s1_valid_o (s1_valid),
    .s1_hit_o   (s1_hit),
    .s1_entry_o (s1_entry),
    .s1_off_o   (s1_off)
  );

  logic unused_flag;
  assign unused_flag = wr_data_i[NH_W];

  lpm_l2_stage #(
    .L2_W(L2_W), .NUM_BLK(NUM_BLK), .NH_W(NH_W), .DEFAULT_NH(DEFAULT_NH)
  ) u_l2 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s1_valid_i  (s1_valid),
    .s1_hit_i    (s1_hit),
    .s1_entry_i  (s1_entry),
    .s1_off_i    (s1_off),
    .wr_en_i     (wr_l2),
    .wr_idx_i    (wr_addr_i[L2_IDX_W-1:0]),
    .wr_nh_i     (wr_data_i[NH_W-1:0]),
    .res_valid_o (res_valid_o),
    .res_nh_o    (res_nh_o),
    .res_lvl2_o  (res_lvl2_o)
  );
endmodule

// File: rtl/lpm_lookup_checker.sv
module lpm_lookup_checker #(
  parameter int NH_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_valid_i,
  input logic            res_valid_o,
  input logic [NH_W-1:0] res_nh_o,
  input logic            res_lvl2_o
);
  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  assert_fixed_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd2) |-> (res_valid_o == $past(lk_valid_i, 2)));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (res_nh_o == '0 && !res_lvl2_o));

  assert_lvl2_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_lvl2_o |-> res_valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_clears_R6: assert (!res_valid_o);
  end
endmodule

bind prefix_lookup_engine lpm_lookup_checker #(.NH_W(NH_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .res_valid_o (res_valid_o),
  .res_nh_o    (res_nh_o),
  .res_lvl2_o  (res_lvl2_o)
);

// File: tb/prefix_lookup_engine_tb.sv
module prefix_lookup_engine_tb;
  localparam int         L1_W  = 10;
  localparam int         NBLK  = 8;
  localparam int         WA_W  = 11;
  localparam logic [7:0] DFLT  = 8'hFE;
  localparam int         NP    = 7;
  localparam int         NV    = 13;

  // {prefix[31:0], length[4:0], next_hop[7:0]}
  localparam logic [44:0] PFX [NP] = '{
    {32'h0A000000, 5'd8,  8'd11},
    {32'hC0A80000, 5'd16, 8'd16},
    {32'h0A490000, 5'd18, 8'd14},
    {32'h0A400000, 5'd10, 8'd12},
    {32'h80000000, 5'd1,  8'd17},
    {32'h0A480000, 5'd13, 8'd13},
    {32'hC0000000, 5'd2,  8'd15}
  };
  // {address, expected next hop, expected lvl2}
  localparam logic [40:0] VEC [NV] = '{
    {32'h0A000001, 8'd11, 1'b0},
    {32'h0A400000, 8'd12, 1'b1},
    {32'h0A480000, 8'd13, 1'b1},
    {32'h0A490000, 8'd14, 1'b1},
    {32'h0A4BFFFF, 8'd13, 1'b1},
    {32'h0A7FFFFF, 8'd12, 1'b1},
    {32'h0B000000, DFLT,  1'b0},
    {32'hC0A80001, 8'd16, 1'b1},
    {32'hC0A40000, 8'd15, 1'b1},
    {32'hC1000000, 8'd15, 1'b0},
    {32'h80000000, 8'd17, 1'b0},
    {32'h00000000, DFLT,  1'b0},
    {32'hBFFFFFFF, 8'd17, 1'b0}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            lk_valid_i;
  logic [31:0]     lk_addr_i;
  logic            wr_en_i;
  logic            wr_tbl_i;
  logic [WA_W-1:0] wr_addr_i;
  logic [8:0]      wr_data_i;
  logic            res_valid_o;
  logic [7:0]      res_nh_o;
  logic            res_lvl2_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  prefix_lookup_engine u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
    .wr_en_i(wr_en_i), .wr_tbl_i(wr_tbl_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .res_valid_o(res_valid_o), .res_nh_o(res_nh_o), .res_lvl2_o(res_lvl2_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic tbl, input int addr, input logic [8:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_tbl_i = tbl; wr_addr_i = WA_W'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, output logic [7:0] nh, output logic l2);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_addr_i = a;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    @(negedge clk_i);
    nh = res_nh_o; l2 = res_lvl2_o;
  endtask

  function automatic logic [7:0] model_lpm(input logic [31:0] a);
    int best = -1;
    logic [7:0] nh = DFLT;
    for (int p = 0; p < NP; p++) begin
      int len = int'(PFX[p][12:8]);
      logic [31:0] m = (len == 0) ? 32'h0 : (32'hFFFFFFFF << (32 - len));
      if ((((a ^ PFX[p][44:13]) & m) == 0) && len > best) begin
        best = len; nh = PFX[p][7:0];
      end
    end
    return nh;
  endfunction

  logic [8:0] l1_img [1 << L1_W];
  bit         l1_set [1 << L1_W];
  logic [7:0] l2_img [NBLK * 256];
  int         nblk;

  task automatic build_and_load();
    nblk = 0;
    for (int i = 0; i < (1 << L1_W); i++) l1_set[i] = 1'b0;
    for (int len = 0; len <= 18; len++) begin
      for (int p = 0; p < NP; p++) begin
        if (int'(PFX[p][12:8]) == len) begin
          int top = int'(PFX[p][44:35]);
          if (len <= L1_W) begin
            int span = 1 << (L1_W - len);
            int base = top & ~(span - 1);
            for (int k = 0; k < span; k++) begin
              l1_img[base + k] = {1'b0, PFX[p][7:0]};
              l1_set[base + k] = 1'b1;
            end
          end else begin
            int span = 1 << (18 - len);
            int off  = int'(PFX[p][34:27]) & ~(span - 1);
            int b;
            if (!(l1_set[top] && l1_img[top][8])) begin
              b = nblk++;
              for (int o = 0; o < 256; o++)
                l2_img[b*256 + o] = l1_set[top] ? l1_img[top][7:0] : DFLT;
              l1_img[top] = {1'b1, 8'(b)};
              l1_set[top] = 1'b1;
            end
            b = int'(l1_img[top][7:0]);
            for (int k = 0; k < span; k++) l2_img[b*256 + off + k] = PFX[p][7:0];
          end
        end
      end
    end
    for (int i = 0; i < (1 << L1_W); i++)
      if (l1_set[i]) wr(1'b0, i, l1_img[i]);
    for (int i = 0; i < nblk * 256; i++)
      wr(1'b1, i, {1'b0, l2_img[i]});
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] nh;
    logic       l2;
    rst_ni = 1'b0; lk_valid_i = 1'b0; lk_addr_i = '0;
    wr_en_i = 1'b0; wr_tbl_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R6 reset valid", res_valid_o, 0);
    chk("R7 idle nh", res_nh_o, 0);
    rst_ni = 1'b1;

    lookup(32'h0A000001, nh, l2);
    chk("R4 unwritten l1 nh", nh, DFLT);
    chk("R4 unwritten l1 lvl2", l2, 0);

    build_and_load();

    // back-to-back stream, results two cycles behind
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk_i);
      if (i < NV) begin lk_valid_i = 1'b1; lk_addr_i = VEC[i][40:9]; end
      else lk_valid_i = 1'b0;
      if (i < 2) chk("R3 no early result", res_valid_o, 0);
      else begin
        chk("R3 valid in slot", res_valid_o, 1);
        chk("R1/R2 nh vector", res_nh_o, VEC[i-2][8:1]);
        chk("R1/R2 lvl2 vector", res_lvl2_o, VEC[i-2][0]);
        chk("R8 model lpm", res_nh_o, model_lpm(VEC[i-2][40:9]));
      end
    end
    @(negedge clk_i);
    chk("R7 idle after stream nh", res_nh_o, 0);

    wr(1'b0, 44, {1'b0, 8'h21});
    lookup(32'h0B000000, nh, l2);
    chk("R9 overwrite l1", nh, 8'h21);

    // L1 write with lookup in the same cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_tbl_i = 1'b0; wr_addr_i = 11'd44; wr_data_i = {1'b0, 8'h22};
    lk_valid_i = 1'b1; lk_addr_i = 32'h0B000000;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk("R5 l1 same cycle old", res_nh_o, 8'h21);
    @(negedge clk_i);
    chk("R5 l1 next cycle new", res_nh_o, 8'h22);

    // L2 write one cycle after the lookup
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_addr_i = 32'h0A490000;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    wr_en_i = 1'b1; wr_tbl_i = 1'b1; wr_addr_i = 11'h024; wr_data_i = {1'b0, 8'h33};
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R5 l2 later write old", res_nh_o, 8'd14);

    // L2 write in the same cycle as the lookup
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_tbl_i = 1'b1; wr_addr_i = 11'h024; wr_data_i = {1'b0, 8'h34};
    lk_valid_i = 1'b1; lk_addr_i = 32'h0A490000;
    @(negedge clk_i);
    wr_en_i = 1'b0; lk_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R5 l2 same cycle new", res_nh_o, 8'h34);
    chk("R5 l2 lvl2", res_lvl2_o, 1);

    wr(1'b0, 44, {1'b1, 8'd5});
    lookup(32'h0B000000, nh, l2);
    chk("R4 unwritten l2 nh", nh, DFLT);
    chk("R4 unwritten l2 lvl2", l2, 1);

    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    lookup(32'h0A000001, nh, l2);
    chk("R6 tables cleared", nh, DFLT);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule